// File: doc/BRIEF.md
# Pipelined Quarter-Wave Sine Synthesizer

This block is a direct digital synthesis core. A 32-bit phase register gains a frequency tuning word on every enabled clock. The top bits of the phase become a signed sine sample through a table that covers only the first quarter of a period. The other three quarters are rebuilt from it by mirroring the table address and negating the magnitude. The output frequency is `f_clk * ftw / 2^32`. The sample stream is meant to feed a converter downstream.

The 32-bit phase addition is split into four 8-bit slices, so no adder is wider than 9 bits. Each slice is one register stage later than the slice below it, and the carry between slices is registered. Each slice of the tuning word is delayed to match the slice it feeds. After the adder, each slice of the sum is realigned by its own delay line. The result is the same phase that a single-cycle adder would produce, at a fixed latency.

A two-state fill controller raises the valid strobe once the pipeline holds real data. Its states are FILL_ST, entered on reset, where it counts enabled clocks, and RUN_ST. The transition FILL_ST to RUN_ST happens on the fifth enabled clock after reset. RUN_ST loops on itself until the next reset. A low enable freezes every register in the block.

Top module: `dds_quarter_sine`

## Requirements
- R1: While `rst` is high on a clock edge, `sample_o` and `valid_o` are cleared to 0 at that edge.
- R2: `valid_o` stays 0 for the first four enabled clocks after reset, becomes 1 on the fifth, and then stays 1 until the next reset.
- R3: The phase behaves as a 32-bit accumulator that wraps modulo 2^32: P(n) = P(n-1) + W(n-1). W(n-1) is the `ftw` value sampled on the previous enabled clock. Both P and the sampled word start at 0 after reset.
- R4: The sample present after enabled clock n is derived from P(n-5).
- R5: Phase bits [31:30] select the quadrant, and phase bits [29:22] give the table address a. Every 10-bit code of these bits produces a sample.
- R6: In quadrants 1 and 3, the table is read at 255-a (bit inversion). The sample at code 256+(255-a) therefore equals the sample at code a exactly.
- R7: In quadrants 2 and 3, the sample is the exact two's complement negation of the magnitude read. Codes that differ only in bit 9 give samples of opposite sign and equal size.
- R8: Table entry k holds an unsigned 15-bit magnitude within 64 LSB of round(32767*sin((2k+1)*pi/1024)).
- R9: When `en` is low, the phase, the table output, `sample_o` and `valid_o` all hold, and the `ftw` value on that clock is ignored.
- R10: A tuning word that changes on every enabled clock yields the same phase sequence as an unpipelined accumulator, including carries that cross slice boundaries.
- R11: `sample_o` never takes the value -32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable for the whole pipeline |
| ftw | input | 32 | Frequency tuning word, added to the phase each enabled clock |
| sample_o | output | 16 | Signed sine sample |
| valid_o | output | 1 | High once the pipeline has filled after reset |

## Verification
The hard case is a new tuning word taking effect in the same clock that a carry is crossing from one slice into the next. If the word skew or carry timing were off, the slices would mix old and new words. To provoke this, the bench changes the word on every enabled clock, draws values that carry out of every slice (all-ones, near-all-ones, random) and inserts random enable gaps. Every sample is judged against an unpipelined reference accumulator read five enabled steps back. A separate sweep of all 1024 codes checks the mirror and negation symmetries bit-exactly.

// File: rtl/dds_pkg.sv
package dds_pkg;

    // Fill controller states
    typedef enum logic [0:0] {
        FILL_ST = 1'b0,
        RUN_ST  = 1'b1
    } fill_state_e;

endpackage

// File: rtl/dds_delay_line.sv
module dds_delay_line #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        if (DEPTH == 0) begin : g_wire
            logic unused_ctl;
            assign unused_ctl = ^{clk, rst, en};
            assign q = d;
        end else begin : g_regs
            logic [WIDTH-1:0] stage_q [DEPTH];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
                end else if (en) begin
                    stage_q[0] <= d;
                    for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
                end
            end
            assign q = stage_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/dds_phase_pipe.sv
module dds_phase_pipe #(
    parameter int PHASE_W = 32,
    parameter int SLICE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [PHASE_W-1:0] ftw,
    output logic [PHASE_W-1:0] phase_o
);

    localparam int NS = PHASE_W / SLICE_W;

    logic [PHASE_W-1:0] word_q;
    logic [PHASE_W-1:0] acc_q;
    logic [NS-1:0]      cy_q;

    // Word capture: the stage-one register for tuning word updates
    always_ff @(posedge clk) begin
        if (rst)     word_q <= '0;
        else if (en) word_q <= ftw;
    end

    generate
        for (genvar k = 0; k < NS; k++) begin : g_slice
            logic [SLICE_W-1:0] wdel;
            logic               cin;
            logic [SLICE_W:0]   sum;

            // Slice k of the word runs k steps late, in step with its adder
            dds_delay_line #(.WIDTH(SLICE_W), .DEPTH(k)) u_wskew (
                .clk (clk),
                .rst (rst),
                .en  (en),
                .d   (word_q[k*SLICE_W +: SLICE_W]),
                .q   (wdel)
            );

            if (k == 0) begin : g_cin0
                assign cin = 1'b0;
            end else begin : g_cinn
                assign cin = cy_q[k-1];
            end

            assign sum = {1'b0, acc_q[k*SLICE_W +: SLICE_W]}
                       + {1'b0, wdel}
                       + {{SLICE_W{1'b0}}, cin};

            always_ff @(posedge clk) begin
                if (rst) begin
                    acc_q[k*SLICE_W +: SLICE_W] <= '0;
                    cy_q[k]                     <= 1'b0;
                end else if (en) begin
                    acc_q[k*SLICE_W +: SLICE_W] <= sum[SLICE_W-1:0];
                    cy_q[k]                     <= sum[SLICE_W];
                end
            end

            // Realign: the lowest slice waits longest
            dds_delay_line #(.WIDTH(SLICE_W), .DEPTH(NS-1-k)) u_dskew (
                .clk (clk),
                .rst (rst),
                .en  (en),
                .d   (acc_q[k*SLICE_W +: SLICE_W]),
                .q   (phase_o[k*SLICE_W +: SLICE_W])
            );
        end
    endgenerate

    logic unused_top_carry;
    assign unused_top_carry = cy_q[NS-1];

    // R9: aligned phase frozen while disabled
    assert_phase_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(phase_o));

endmodule

// File: rtl/dds_quarter_rom.sv
module dds_quarter_rom #(
    parameter int ADDR_W = 8,
    parameter int MAG_W  = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [MAG_W-1:0]  mag_o
);

    localparam int     DEPTH = 1 << ADDR_W;
    localparam longint HALF  = longint'(1) << (ADDR_W + 2); // pi in half-step units

    // Rational sine approximation at the midpoint of entry i
    function automatic logic [MAG_W-1:0] quarter_mag(input int i);
        longint x, prod, full, num, den;
        x    = 2 * longint'(i) + 1;
        prod = x * (HALF - x);
        full = (longint'(1) << MAG_W) - 1;
        num  = 16 * prod * full;
        den  = 5 * HALF * HALF - 4 * prod;
        return MAG_W'((num + den / 2) / den);
    endfunction

    logic [MAG_W-1:0] table_w [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_entry
            localparam logic [MAG_W-1:0] ENTRY = quarter_mag(i);
            assign table_w[i] = ENTRY;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)     mag_o <= '0;
        else if (en) mag_o <= table_w[addr_i];
    end

    // R9: table output frozen while disabled
    assert_mag_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(mag_o));

endmodule

// File: rtl/dds_quarter_sine.sv
module dds_quarter_sine #(
    parameter int PHASE_W = 32,
    parameter int SLICE_W = 8,
    parameter int ADDR_W  = 8,
    parameter int MAG_W   = 15
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic [PHASE_W-1:0]       ftw,
    output logic signed [MAG_W:0]    sample_o,
    output logic                     valid_o
);

    import dds_pkg::*;

    localparam int NS  = PHASE_W / SLICE_W;
    localparam int LAT = NS + 1;
    localparam int CW  = $clog2(LAT);
    localparam int LOW = PHASE_W - ADDR_W - 2;

    logic [PHASE_W-1:0] phase;
    logic [1:0]         quad;
    logic [ADDR_W-1:0]  raw_addr;
    logic [ADDR_W-1:0]  addr;
    logic [MAG_W-1:0]   mag;
    logic               neg_q;
    logic signed [MAG_W:0] mag_s;

    dds_phase_pipe #(.PHASE_W(PHASE_W), .SLICE_W(SLICE_W)) u_pipe (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .ftw     (ftw),
        .phase_o (phase)
    );

    assign quad     = phase[PHASE_W-1 -: 2];
    assign raw_addr = phase[PHASE_W-3 -: ADDR_W];
    assign addr     = quad[0] ? ~raw_addr : raw_addr;

    logic unused_low;
    assign unused_low = ^phase[LOW-1:0];

    dds_quarter_rom #(.ADDR_W(ADDR_W), .MAG_W(MAG_W)) u_rom (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .addr_i (addr),
        .mag_o  (mag)
    );

    // Sign bit travels alongside the table read cycle
    always_ff @(posedge clk) begin
        if (rst)     neg_q <= 1'b0;
        else if (en) neg_q <= quad[1];
    end

    assign mag_s = $signed({1'b0, mag});

    always_ff @(posedge clk) begin
        if (rst)     sample_o <= '0;
        else if (en) sample_o <= neg_q ? -mag_s : mag_s;
    end

    // Fill controller
    fill_state_e    state_q;
    logic [CW-1:0]  fill_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= FILL_ST;
            fill_cnt_q <= '0;
        end else if (en) begin
            unique case (state_q)
                FILL_ST: begin
                    if (fill_cnt_q == CW'(LAT - 1)) state_q <= RUN_ST;
                    else                            fill_cnt_q <= fill_cnt_q + 1'b1;
                end
                RUN_ST: state_q <= RUN_ST;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            FILL_ST: valid_o = 1'b0;
            RUN_ST:  valid_o = 1'b1;
        endcase
    end

    // R9: outputs frozen while disabled
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(sample_o) && $stable(valid_o)));

    // R2: once valid, stays valid until reset
    assert_valid_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> valid_o);

    // R2: valid only rises on an enabled clock
    assert_valid_rise_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_o) |-> $past(en));

    // R11: most negative code never produced
    assert_no_minneg_R11: assert property (@(posedge clk) disable iff (rst)
        sample_o != {1'b1, {MAG_W{1'b0}}});

endmodule

// File: tb/dds_quarter_sine_tb.sv
`timescale 1ns/1ps
module dds_quarter_sine_tb;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               en  = 1'b0;
    logic [31:0]        ftw = '0;
    logic signed [15:0] sample_o;
    logic               valid_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dds_quarter_sine u_dut (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .ftw      (ftw),
        .sample_o (sample_o),
        .valid_o  (valid_o)
    );

    // Reference: unpipelined accumulator plus history of five steps
    logic [31:0] m_acc, m_w;
    logic [31:0] hist [0:5];
    int          m_steps;
    logic signed [15:0] prev_s;
    bit          rec;
    int          arr  [1024];
    bit          seen [1024];
    bit          p1_ok, p2_ok;
    logic [9:0]  p1_c, p2_c;
    int          p1_s, p2_s;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ideal(input logic [9:0] code);
        int  idx, m;
        real v;
        idx = code[8] ? 255 - int'(code[7:0]) : int'(code[7:0]);
        v   = 32767.0 * $sin((2.0 * idx + 1.0) * 3.14159265358979 / 1024.0);
        m   = $rtoi(v + 0.5);
        return code[9] ? -m : m;
    endfunction

    task automatic model_reset();
        m_acc = '0; m_w = '0; m_steps = 0;
        for (int i = 0; i <= 5; i++) hist[i] = '0;
        p1_ok = 1'b0; p2_ok = 1'b0;
    endtask

    task automatic cyc(input logic e, input logic [31:0] w);
        logic [9:0] code;
        int         exp_s, diff;
        en  = e;
        ftw = w;
        @(posedge clk);
        if (e) begin
            m_acc = m_acc + m_w;
            m_w   = w;
            for (int i = 5; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = m_acc;
            m_steps++;
        end
        @(negedge clk);
        if (!e) chk(sample_o == prev_s, "R9 hold", int'(sample_o), int'(prev_s));
        if (m_steps >= 5) begin
            chk(valid_o == 1'b1, "R2 valid high", int'(valid_o), 1);
            code  = hist[5][31:22];
            exp_s = ideal(code);
            diff  = int'(sample_o) - exp_s;
            if (diff < 0) diff = -diff;
            chk(diff <= 64, "R4/R8/R3/R10 sample", int'(sample_o), exp_s);
            chk(sample_o != -16'sd32768, "R11 range", int'(sample_o), -32767);
            if (e) begin
                if (p1_ok && (code == (p1_c ^ 10'h200)))
                    chk(int'(sample_o) == -p1_s, "R7 negation", int'(sample_o), -p1_s);
                if (p2_ok && (code == (p2_c ^ 10'h200)))
                    chk(int'(sample_o) == -p2_s, "R7 negation", int'(sample_o), -p2_s);
                p2_ok = p1_ok; p2_c = p1_c; p2_s = p1_s;
                p1_ok = 1'b1;  p1_c = code; p1_s = int'(sample_o);
                if (rec) begin
                    arr[code]  = int'(sample_o);
                    seen[code] = 1'b1;
                end
            end
        end else begin
            chk(valid_o == 1'b0, "R2 valid low during fill", int'(valid_o), 0);
        end
        prev_s = sample_o;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int cnt;
        logic [31:0] w;
        rec = 1'b0;
        for (int i = 0; i < 1024; i++) begin arr[i] = 0; seen[i] = 1'b0; end
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(sample_o == 16'sd0, "R1 sample reset", int'(sample_o), 0);
        chk(valid_o == 1'b0, "R1 valid reset", int'(valid_o), 0);
        rst    = 1'b0;
        prev_s = sample_o;

        // Full sweep: one table step per clock (R5, R6, R7, R8)
        rec = 1'b1;
        for (int n = 0; n < 1036; n++) cyc(1'b1, 32'h0040_0000);
        rec = 1'b0;
        cnt = 0;
        for (int c = 0; c < 1024; c++) if (seen[c]) cnt++;
        chk(cnt == 1024, "R5 all codes", cnt, 1024);
        for (int a = 0; a < 256; a++) begin
            chk(arr[256 + 255 - a] == arr[a], "R6 mirror", arr[256 + 255 - a], arr[a]);
            chk(arr[512 + a] == -arr[a], "R7 second half", arr[512 + a], -arr[a]);
            chk(arr[768 + 255 - a] == -arr[a], "R7 fourth quarter", arr[768 + 255 - a], -arr[a]);
        end

        // Half turn and quarter turn per step (R7 exact)
        for (int n = 0; n < 16; n++) cyc(1'b1, 32'h8000_0000);
        for (int n = 0; n < 16; n++) cyc(1'b1, 32'h4000_0000);

        // Word changes every enabled clock, carries across slices, enable gaps (R3, R9, R10)
        for (int n = 0; n < 4000; n++) begin
            case ($urandom_range(0, 4))
                0:       w = 32'hFFFF_FFFF;
                1:       w = 32'h00FF_FF01 + $urandom_range(0, 255);
                2:       w = {24'h0, 8'($urandom_range(0, 255))} | 32'h00FF_FF00;
                default: w = $urandom;
            endcase
            cyc(($urandom_range(0, 3) != 0), w);
        end

        // Reset in mid-run, then refill (R1, R2)
        en  = 1'b1;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(sample_o == 16'sd0, "R1 sample mid-run reset", int'(sample_o), 0);
        chk(valid_o == 1'b0, "R1 valid mid-run reset", int'(valid_o), 0);
        model_reset();
        rst    = 1'b0;
        prev_s = sample_o;
        for (int n = 0; n < 12; n++) cyc(n != 2, 32'h0123_4567);
        for (int n = 0; n < 200; n++) cyc(1'b1, 32'h0000_0001 + 32'h0100_0000 * n);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule